// File: doc/BRIEF.md
# Eight-Bit Stack Processor Core

This block is a small 8-bit processor. It has a 256-byte memory that holds both code and data, eight 8-bit general registers and an 8-bit program counter. The top register doubles as the stack pointer. Each clock cycle the core reads the opcode byte at the program counter and the two bytes after it, decodes the opcode and executes it in that same cycle. The instruction set covers register load, add, multiply, a store through a register pointer, push and pop, subroutine call and return, an indirect jump, emitting a register as a number or as a character, and halt.

The memory is inside the block. A loader write port fills it while the core is held in reset. Results leave through a small output port: a one-cycle strobe, a data byte and a flag that marks the byte as a character rather than a number. A sticky halted flag shows that execution has stopped.

Top module: `cpu8_core`

## Requirements
- R1: While rst_n is low, out_stb and halted are 0. On release the registers are 0, except the stack register (index 7), which holds 0xF3. The program counter is 0.
- R2: The core executes one instruction per clock. Unless the instruction redirects the program counter, the program counter advances by opcode bits 7:6 plus one, modulo 256. A program that runs N instructions before its halt raises halted at the (N+1)-th clock edge after reset release.
- R3: Load-immediate (0x82) writes operand byte B into the register named by operand A. Add (0xA0) and multiply (0xA2) replace register A with the low 8 bits of A+B or A*B. A register is named by the low 3 bits of its operand byte.
- R4: Emit-number (0x47) and emit-character (0x48) put register A on out_val, with out_is_char at 0 or 1. out_stb is high for exactly the cycle that follows the instruction's clock edge.
- R5: Push (0x45) writes register A to memory at the stack register's address and then decrements the stack register. Pop (0x46) first increments the stack register and then loads register A from that address. Popping into the stack register leaves the popped byte in it. Pushing the stack register stores its value from before the decrement.
- R6: Store (0x84) writes register B to the memory address held in register A.
- R7: Jump (0x54) loads the program counter from register A. Call (0x50) pushes the address of the byte after the call instruction (its own address plus 2) and then jumps to register A. Return (0x11) pops the program counter.
- R8: Halt (0x01), and every opcode not listed here, sets halted. From then on halted stays 1, the program counter and stack register stay as they are, and out_stb stays 0.
- R9: When ld_we is high, ld_data is written into memory at ld_addr, and the core executes the loaded bytes after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_we | input | 1 | Loader write enable, used while in reset |
| ld_addr | input | 8 | Loader write address |
| ld_data | input | 8 | Loader write data |
| out_stb | output | 1 | One-cycle strobe for an emitted byte |
| out_val | output | 8 | Emitted register value |
| out_is_char | output | 1 | 1 when the emitted byte is a character |
| halted | output | 1 | Sticky stop indication |

## Verification
Two effects can land on the stack register in the same cycle. Popping into it both increments it and loads it, and pushing it both stores it and decrements it. A call likewise writes the stack and redirects the program counter in one cycle. A directed program pushes the stack register, pops it back into another register and finally pops straight into the stack register. A separate program calls a subroutine that pops and re-pushes its own return address. The emitted values are compared with a bench model that applies the ordering stated in R5 and R7. Random straight-line programs of loads, arithmetic and stack traffic add more coverage, and the number of cycles to halt is counted to confirm single-cycle execution.

// File: rtl/cpu8_pkg.sv
package cpu8_pkg;

    localparam int unsigned WORD_W = 8;

    typedef logic [WORD_W-1:0] word_t;

    // opcode byte values
    localparam word_t OPC_STOP  = 8'h01;
    localparam word_t OPC_LOADI = 8'h82;
    localparam word_t OPC_SHOWN = 8'h47;
    localparam word_t OPC_SHOWC = 8'h48;
    localparam word_t OPC_CALL  = 8'h50;
    localparam word_t OPC_RET   = 8'h11;
    localparam word_t OPC_PUSH  = 8'h45;
    localparam word_t OPC_POP   = 8'h46;
    localparam word_t OPC_STORE = 8'h84;
    localparam word_t OPC_JUMP  = 8'h54;
    localparam word_t OPC_ADD   = 8'hA0;
    localparam word_t OPC_MUL   = 8'hA2;

    typedef enum logic [3:0] {
        K_STOP, K_LOADI, K_SHOWN, K_SHOWC, K_CALL, K_RET,
        K_PUSH, K_POP, K_STORE, K_JUMP, K_ARITH
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        logic       is_mul;   // arithmetic variant select
        logic [1:0] n_opnd;   // operand bytes following the opcode
    } dec_t;

endpackage

// File: rtl/cpu8_decode.sv
module cpu8_decode
    import cpu8_pkg::*;
(
    input  word_t opcode,
    output dec_t  dec
);
    always_comb begin
        dec.n_opnd = opcode[WORD_W-1:WORD_W-2];
        dec.is_mul = 1'b0;
        case (opcode)
            OPC_LOADI: dec.kind = K_LOADI;
            OPC_SHOWN: dec.kind = K_SHOWN;
            OPC_SHOWC: dec.kind = K_SHOWC;
            OPC_CALL:  dec.kind = K_CALL;
            OPC_RET:   dec.kind = K_RET;
            OPC_PUSH:  dec.kind = K_PUSH;
            OPC_POP:   dec.kind = K_POP;
            OPC_STORE: dec.kind = K_STORE;
            OPC_JUMP:  dec.kind = K_JUMP;
            OPC_ADD:   dec.kind = K_ARITH;
            OPC_MUL: begin
                dec.kind   = K_ARITH;
                dec.is_mul = 1'b1;
            end
            default:   dec.kind = K_STOP;  // explicit stop and every unknown code
        endcase
    end
endmodule

// File: rtl/cpu8_alu.sv
module cpu8_alu
    import cpu8_pkg::*;
(
    input  word_t a,
    input  word_t b,
    input  logic  is_mul,
    output word_t y
);
    // both results truncate to the word width, i.e. wrap modulo 2**WORD_W
    always_comb begin
        if (is_mul) y = a * b;
        else        y = a + b;
    end
endmodule

// File: rtl/cpu8_mem.sv
module cpu8_mem
    import cpu8_pkg::*;
#(
    parameter int unsigned AW  = 8,
    parameter int unsigned NRD = 4
) (
    input  logic                   clk,
    input  logic                   we,
    input  logic [AW-1:0]          waddr,
    input  word_t                  wdata,
    input  logic [NRD-1:0][AW-1:0] raddr,
    output word_t [NRD-1:0]        rdata
);
    localparam int unsigned DEPTH = 2 ** AW;

    word_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = mem_q[raddr[g]];
    end
endmodule

// File: rtl/cpu8_core.sv
module cpu8_core
    import cpu8_pkg::*;
#(
    parameter int unsigned NREG   = 8,
    parameter logic [7:0]  SP_RST = 8'hF3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld_we,
    input  logic [7:0] ld_addr,
    input  logic [7:0] ld_data,
    output logic       out_stb,
    output logic [7:0] out_val,
    output logic       out_is_char,
    output logic       halted
);
    localparam int unsigned RIW    = $clog2(NREG);
    localparam int unsigned SP_IDX = NREG - 1;
    localparam int unsigned AW     = WORD_W;
    localparam int unsigned NRD    = 4;   // opcode, operand A, operand B, stack top

    typedef struct packed {
        word_t [NREG-1:0] regs;
        word_t            pc;
        logic             halted;
        logic             stb;
        word_t            val;
        logic             is_char;
    } state_t;

    state_t cur_q, nxt_d;

    logic [NRD-1:0][AW-1:0] rd_addr;
    word_t [NRD-1:0]        rd_data;
    word_t                  opcode, opa, opb, pop_w;
    logic [RIW-1:0]         ia, ib;
    word_t                  ra, rb, sp_w, pc_w, alu_y;
    dec_t                   dec;
    logic                   cpu_we;
    word_t                  cpu_waddr, cpu_wdata;
    logic                   unused_opnd_bits;

    assign sp_w = cur_q.regs[SP_IDX];
    assign pc_w = cur_q.pc;

    assign rd_addr[0] = pc_w;
    assign rd_addr[1] = pc_w + word_t'(1);
    assign rd_addr[2] = pc_w + word_t'(2);
    assign rd_addr[3] = sp_w + word_t'(1);

    assign opcode = rd_data[0];
    assign opa    = rd_data[1];
    assign opb    = rd_data[2];
    assign pop_w  = rd_data[3];

    assign ia = opa[RIW-1:0];
    assign ib = opb[RIW-1:0];
    assign ra = cur_q.regs[ia];
    assign rb = cur_q.regs[ib];
    assign unused_opnd_bits = ^{opa[WORD_W-1:RIW], opb[WORD_W-1:RIW]};

    cpu8_mem #(.AW(AW), .NRD(NRD)) u_mem (
        .clk   (clk),
        .we    (ld_we | cpu_we),
        .waddr (ld_we ? ld_addr : cpu_waddr),
        .wdata (ld_we ? ld_data : cpu_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    cpu8_decode u_dec (
        .opcode (opcode),
        .dec    (dec)
    );

    cpu8_alu u_alu (
        .a      (ra),
        .b      (rb),
        .is_mul (dec.is_mul),
        .y      (alu_y)
    );

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.stb = 1'b0;
        cpu_we    = 1'b0;
        cpu_waddr = sp_w;
        cpu_wdata = ra;
        if (rst_n && !cur_q.halted) begin
            nxt_d.pc = pc_w + word_t'(dec.n_opnd) + word_t'(1);
            unique case (dec.kind)
                K_LOADI: nxt_d.regs[ia] = opb;
                K_SHOWN, K_SHOWC: begin
                    nxt_d.stb     = 1'b1;
                    nxt_d.val     = ra;
                    nxt_d.is_char = (dec.kind == K_SHOWC);
                end
                K_ARITH: nxt_d.regs[ia] = alu_y;
                K_PUSH: begin
                    cpu_we               = 1'b1;
                    nxt_d.regs[SP_IDX]   = sp_w - word_t'(1);
                end
                K_POP: begin
                    nxt_d.regs[SP_IDX]   = sp_w + word_t'(1);
                    nxt_d.regs[ia]       = pop_w;   // later write wins for the stack register
                end
                K_STORE: begin
                    cpu_we    = 1'b1;
                    cpu_waddr = ra;
                    cpu_wdata = rb;
                end
                K_JUMP: nxt_d.pc = ra;
                K_CALL: begin
                    cpu_we             = 1'b1;
                    cpu_wdata          = pc_w + word_t'(2);
                    nxt_d.regs[SP_IDX] = sp_w - word_t'(1);
                    nxt_d.pc           = ra;
                end
                K_RET: begin
                    nxt_d.regs[SP_IDX] = sp_w + word_t'(1);
                    nxt_d.pc           = pop_w;
                end
                default: begin
                    nxt_d.halted = 1'b1;
                    nxt_d.pc     = pc_w;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q              <= '0;
            cur_q.regs[SP_IDX] <= SP_RST;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign out_stb     = cur_q.stb;
    assign out_val     = cur_q.val;
    assign out_is_char = cur_q.is_char;
    assign halted      = cur_q.halted;

endmodule

// File: rtl/cpu8_core_chk.sv
module cpu8_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       halted,
    input logic       out_stb,
    input logic [7:0] pc,
    input logic [7:0] sp,
    input logic [7:0] opcode
);
    // R8
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R8
    halt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> ($stable(pc) && $stable(sp) && !out_stb));

    // R2
    loadi_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && opcode == 8'h82) |=> (pc == $past(pc) + 8'd3));

    // R5
    push_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && opcode == 8'h45) |=> (sp == $past(sp) - 8'd1));

    // R4
    strobe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && opcode != 8'h47 && opcode != 8'h48) |=> !out_stb);
endmodule

bind cpu8_core cpu8_core_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .halted  (halted),
    .out_stb (out_stb),
    .pc      (pc_w),
    .sp      (sp_w),
    .opcode  (opcode)
);

// File: tb/tb_cpu8_core.sv
module tb_cpu8_core;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_we = 1'b0;
    logic [7:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic       out_stb, out_is_char, halted;
    logic [7:0] out_val;

    cpu8_core dut (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .out_stb(out_stb), .out_val(out_val), .out_is_char(out_is_char), .halted(halted)
    );

    always #4 clk = ~clk;   // 125 MHz

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] pmem [256];
    int         wp;
    logic [7:0] ev [256];
    bit         ec [256];
    int         en, esteps;
    logic [7:0] gv [256];
    bit         gc [256];
    int         gn, hcyc;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 256; i++) pmem[i] = 8'h00;
        wp = 0;
    endtask

    task automatic e1(input logic [7:0] b);
        pmem[wp[7:0]] = b;
        wp++;
    endtask

    task automatic e2(input logic [7:0] b0, input logic [7:0] b1);
        e1(b0); e1(b1);
    endtask

    task automatic e3(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
        e1(b0); e1(b1); e1(b2);
    endtask

    // reference interpreter written from the requirements
    task automatic model();
        logic [7:0] m [256];
        logic [7:0] r [8];
        logic [7:0] pc, op, a, b, npc;
        bit stop;
        for (int i = 0; i < 256; i++) m[i] = pmem[i];
        for (int i = 0; i < 8; i++) r[i] = 8'h00;
        r[7] = 8'hF3;
        pc = 8'h00; en = 0; esteps = 0;
        for (int s = 0; s < 4000; s++) begin
            op = m[pc]; a = m[pc + 8'd1]; b = m[pc + 8'd2];
            npc = pc + {6'd0, op[7:6]} + 8'd1;
            stop = 1'b0;
            case (op)
                8'h82: r[a[2:0]] = b;
                8'h47, 8'h48: begin
                    if (en < 256) begin ev[en] = r[a[2:0]]; ec[en] = (op == 8'h48); en++; end
                end
                8'hA0: r[a[2:0]] = r[a[2:0]] + r[b[2:0]];
                8'hA2: r[a[2:0]] = r[a[2:0]] * r[b[2:0]];
                8'h45: begin m[r[7]] = r[a[2:0]]; r[7] = r[7] - 8'd1; end
                8'h46: begin r[7] = r[7] + 8'd1; r[a[2:0]] = m[r[7]]; end
                8'h84: m[r[a[2:0]]] = r[b[2:0]];
                8'h54: npc = r[a[2:0]];
                8'h50: begin m[r[7]] = pc + 8'd2; r[7] = r[7] - 8'd1; npc = r[a[2:0]]; end
                8'h11: begin r[7] = r[7] + 8'd1; npc = m[r[7]]; end
                default: stop = 1'b1;
            endcase
            if (stop) break;
            esteps++;
            pc = npc;
        end
    endtask

    task automatic run_prog(input string tag);
        bit quiet;
        int lim;
        model();
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            ld_we = 1'b1; ld_addr = 8'(i); ld_data = pmem[i];
        end
        @(negedge clk);
        ld_we = 1'b0;
        // R1 outputs quiet while in reset
        chk(!out_stb && !halted, {tag, " R1 reset outputs"}, int'({out_stb, halted}), 0);
        rst_n = 1'b1;
        gn = 0; hcyc = 0;
        for (int c = 1; c <= 5000; c++) begin
            @(negedge clk);
            if (out_stb && gn < 256) begin gv[gn] = out_val; gc[gn] = out_is_char; gn++; end
            if (halted) begin hcyc = c; break; end
        end
        // R9 loaded program drives the emitted stream
        chk(gn == en, {tag, " R9 emitted count"}, gn, en);
        lim = (gn < en) ? gn : en;
        for (int i = 0; i < lim; i++) begin
            chk(gv[i] == ev[i], $sformatf("%s value #%0d", tag, i), int'(gv[i]), int'(ev[i]));
            chk(gc[i] == ec[i], $sformatf("%s R4 kind #%0d", tag, i), int'(gc[i]), int'(ec[i]));
        end
        chk(hcyc == esteps + 1, {tag, " R2 cycles to halt"}, hcyc, esteps + 1);
        quiet = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (out_stb || !halted) quiet = 1'b0;
        end
        chk(quiet, {tag, " R8 silent after halt"}, int'(quiet), 1);
    endtask

    initial begin
        #1600000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7311));
        repeat (2) @(negedge clk);

        // R1 reset values seen through emits, R4 number vs character
        clear_prog();
        e2(8'h47, 8'h07); e2(8'h47, 8'h00); e3(8'h82, 8'h01, 8'h41); e2(8'h48, 8'h01); e1(8'h01);
        run_prog("R1");

        // R3 wrap and low-bit register naming
        clear_prog();
        e3(8'h82, 8'h00, 8'hC8); e3(8'h82, 8'h09, 8'h64); e3(8'hA0, 8'h00, 8'h11); e2(8'h47, 8'h00);
        e3(8'h82, 8'h02, 8'h10); e3(8'hA2, 8'h02, 8'h02); e2(8'h47, 8'h02);
        e3(8'hA2, 8'h01, 8'h01); e2(8'h47, 8'h01); e1(8'h01);
        run_prog("R3");

        // R5 push/pop ordering including the stack register itself
        clear_prog();
        e3(8'h82, 8'h00, 8'h05); e2(8'h45, 8'h00); e3(8'h82, 8'h00, 8'h09); e2(8'h45, 8'h07);
        e2(8'h46, 8'h01); e2(8'h46, 8'h02); e2(8'h47, 8'h01); e2(8'h47, 8'h02); e2(8'h47, 8'h07);
        e2(8'h46, 8'h07); e2(8'h47, 8'h07); e1(8'h01);
        run_prog("R5");

        // R6 store then read back through a pop
        clear_prog();
        e3(8'h82, 8'h00, 8'h80); e3(8'h82, 8'h01, 8'h5A); e3(8'h84, 8'h00, 8'h01);
        e3(8'h82, 8'h07, 8'h7F); e2(8'h46, 8'h02); e2(8'h47, 8'h02); e1(8'h01);
        run_prog("R6");

        // R7 call, return address, jump over an emit, return
        clear_prog();
        e3(8'h82, 8'h00, 8'h0A); e2(8'h50, 8'h00); e2(8'h47, 8'h03); e1(8'h01); e2(8'h00, 8'h00);
        e3(8'h82, 8'h03, 8'h33); e2(8'h46, 8'h04); e2(8'h47, 8'h04); e2(8'h45, 8'h04);
        e3(8'h82, 8'h01, 8'h1A); e2(8'h54, 8'h01); e2(8'h47, 8'h04); e1(8'h11);
        run_prog("R7");

        // R8 unknown opcodes stop the core
        clear_prog();
        e3(8'h82, 8'h00, 8'h07); e2(8'h47, 8'h00); e1(8'h63); e2(8'h47, 8'h00); e1(8'h01);
        run_prog("R8 unknown");
        clear_prog();
        e3(8'h82, 8'h00, 8'h01); e2(8'h47, 8'h00); e3(8'hA5, 8'h00, 8'h00); e2(8'h47, 8'h00); e1(8'h01);
        run_prog("R8 unknown arith");

        // R3 random straight-line programs
        for (int p = 0; p < 12; p++) begin
            clear_prog();
            for (int k = 0; k < 14; k++) begin
                int sel;
                logic [7:0] ra, rb;
                sel = int'($urandom_range(0, 6));
                ra = 8'($urandom); ra[2:0] = 3'($urandom_range(0, 6));
                rb = 8'($urandom); rb[2:0] = 3'($urandom_range(0, 6));
                case (sel)
                    0: e3(8'h82, ra, 8'($urandom));
                    1: e3(8'hA0, ra, rb);
                    2: e3(8'hA2, ra, rb);
                    3: e2(8'h47, ra);
                    4: e2(8'h48, ra);
                    5: e2(8'h45, ra);
                    default: e2(8'h46, ra);
                endcase
            end
            e1(8'h01);
            run_prog($sformatf("R3 random %0d", p));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule